// File: doc/BRIEF.md
# Odd-Parity Single-Error-Correcting Byte Codec

This block protects one data byte with four check bits, giving a 12-bit word. It has two independent combinational paths. The encode path turns a byte into a protected word. The decode path takes a received word and returns the byte after repair, together with a 4-bit syndrome and two flags. The check bits use odd parity: every check group, counting its own check bit, must hold an odd number of ones.

Word positions are numbered 1 to 12. Position p is carried on word bit p-1. The check bits sit at the power-of-two positions 1, 2, 4 and 8. Check bit k, at position 2^k, covers every position whose binary index has bit k set. A single flipped bit anywhere in the word is located and repaired. Syndromes that point past position 12 are reported and are not acted on. The block sits between a byte source and a narrow storage or link field, with no clock.

Top module: `hamming_odd_codec`

## Requirements
- R1: The encoder places the data byte into positions 12, 11, 10, 9, 7, 6, 5 and 3, in that order from data bit 7 down to data bit 0. Position p is word bit p-1.
- R2: Each check bit at position 2^k (k = 0..3) makes the count of ones across all positions with index bit k set odd.
- R3: Byte 0xB9 (10111001) encodes to 0xB4C (101101001100). Byte 0x00 encodes to 0x08B.
- R4: On decode, syndrome bit k is 1 exactly when the positions with index bit k set hold an even number of ones. The syndrome of a valid word is 0.
- R5: With a zero syndrome, the decoded byte equals the data positions of the received word, and both the error flag and the bad-position flag are 0.
- R6: With a syndrome s from 1 to 12, the bit at position s is inverted before the byte is extracted. The error flag is 1 and the bad-position flag is 0, so any single-bit error returns the original byte.
- R7: With a syndrome from 13 to 15, the byte is taken from the received word without change, and both the error flag and the bad-position flag are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_data | input | 8 | Byte to encode |
| enc_word | output | 12 | Protected word; bit p-1 holds position p |
| dec_word | input | 12 | Received word to check and repair |
| dec_data | output | 8 | Byte after repair |
| dec_syndrome | output | 4 | Odd-parity syndrome of dec_word |
| dec_error | output | 1 | Syndrome is nonzero |
| dec_bad_pos | output | 1 | Syndrome is 13 to 15, so no repair is done |

## Verification
The inline assertions check several round-trip properties whenever the inputs change. On the encode side, every produced word decodes with a zero syndrome and gives back its byte. On the decode side, a clean syndrome means the output byte re-encodes to exactly the received word. A repair means the re-encoded byte differs from the received word in exactly one bit. A bad-position report means the byte is left unrepaired.

Only the bench scenarios can show three further things. First, that the bit ordering matches the fixed layout, including the two known words. Second, that every one of the 256 bytes survives a flip at each of the 12 positions with the flip position reported as the syndrome. Third, that paired flips giving syndromes 13 to 15 raise both flags.

// File: rtl/hamming_odd_codec.sv
module hamming_odd_codec (
  input  logic [7:0]  enc_data,
  output logic [11:0] enc_word,
  input  logic [11:0] dec_word,
  output logic [7:0]  dec_data,
  output logic [3:0]  dec_syndrome,
  output logic        dec_error,
  output logic        dec_bad_pos
);
  localparam int NW = 12;
  localparam int ND = 8;
  localparam int NC = 4;

  function automatic logic [NC-1:0] syndrome_of(input logic [NW-1:0] w);
    logic [NC-1:0] s;
    logic par;
    for (int k = 0; k < NC; k++) begin
      par = 1'b0;
      for (int p = 1; p <= NW; p++)
        if (p[k]) par = par ^ w[p-1];
      s[k] = ~par;
    end
    return s;
  endfunction

  function automatic logic [NW-1:0] place(input logic [ND-1:0] d);
    logic [NW-1:0] w;
    logic [3:0] j;
    w = '0;
    j = '0;
    for (int p = 1; p <= NW; p++)
      if ((p & (p - 1)) != 0) begin
        w[p-1] = d[j[2:0]];
        j = j + 4'd1;
      end
    return w;
  endfunction

  function automatic logic [ND-1:0] extract(input logic [NW-1:0] w);
    logic [ND-1:0] d;
    logic [3:0] j;
    d = '0;
    j = '0;
    for (int p = 1; p <= NW; p++)
      if ((p & (p - 1)) != 0) begin
        d[j[2:0]] = w[p-1];
        j = j + 4'd1;
      end
    return d;
  endfunction

  function automatic logic [NW-1:0] encode(input logic [ND-1:0] d);
    logic [NW-1:0] w;
    logic [NC-1:0] s;
    w = place(d);
    s = syndrome_of(w);
    for (int k = 0; k < NC; k++)
      w[(1 << k) - 1] = s[k];
    return w;
  endfunction

  always_comb begin
    enc_word = encode(enc_data);
    // R2, R4: every produced word carries a zero odd-parity syndrome
    a_r2_valid_word: assert (syndrome_of(enc_word) == '0);
    // R1: data positions of the word give back the byte
    a_r1_roundtrip: assert (extract(enc_word) == enc_data);
  end

  logic [NW-1:0] fixed_word;
  int            flip_idx;

  always_comb begin
    dec_syndrome = syndrome_of(dec_word);
    fixed_word   = dec_word;
    flip_idx     = int'(dec_syndrome) - 1;
    if (dec_syndrome != '0 && int'(dec_syndrome) <= NW)
      fixed_word[flip_idx] = ~fixed_word[flip_idx];
    dec_data    = extract(fixed_word);
    dec_error   = dec_syndrome != '0;
    dec_bad_pos = int'(dec_syndrome) > NW;

    // R5: clean word re-encodes to itself with no flag raised
    if (!dec_error)
      a_r5_clean_pass: assert (encode(dec_data) == dec_word && !dec_bad_pos);
    // R6: a repair is exactly one bit away from the received word
    if (dec_error && !dec_bad_pos)
      a_r6_single_fix: assert ($countones(encode(dec_data) ^ dec_word) == 1);
    // R7: out-of-range syndrome leaves the byte unrepaired
    if (dec_bad_pos)
      a_r7_no_repair: assert (dec_error && dec_data == extract(dec_word));
  end
endmodule

// File: tb/hamming_odd_codec_tb.sv
module hamming_odd_codec_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  enc_data = '0;
  logic [11:0] enc_word;
  logic [11:0] dec_word = '0;
  logic [7:0]  dec_data;
  logic [3:0]  dec_syndrome;
  logic        dec_error;
  logic        dec_bad_pos;

  int applied = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [25:0] sb_exp[$];
  string       sb_tag[$];

  always #10 clk = ~clk;

  hamming_odd_codec u_dut (
    .enc_data(enc_data), .enc_word(enc_word),
    .dec_word(dec_word), .dec_data(dec_data),
    .dec_syndrome(dec_syndrome), .dec_error(dec_error),
    .dec_bad_pos(dec_bad_pos)
  );

  function automatic logic [11:0] benc(input logic [7:0] d);
    logic [11:0] w;
    w = '0;
    w[11] = d[7]; w[10] = d[6]; w[9] = d[5]; w[8] = d[4];
    w[6]  = d[3]; w[5]  = d[2]; w[4] = d[1]; w[2] = d[0];
    w[0] = ~(w[2] ^ w[4] ^ w[6] ^ w[8] ^ w[10]);
    w[1] = ~(w[2] ^ w[5] ^ w[6] ^ w[9] ^ w[10]);
    w[3] = ~(w[4] ^ w[5] ^ w[6] ^ w[11]);
    w[7] = ~(w[8] ^ w[9] ^ w[10] ^ w[11]);
    return w;
  endfunction

  function automatic logic [7:0] bext(input logic [11:0] w);
    return {w[11], w[10], w[9], w[8], w[6], w[5], w[4], w[2]};
  endfunction

  task automatic apply(input logic [7:0] d, input logic [11:0] w,
                       input logic [11:0] exp_enc, input logic [7:0] exp_dat,
                       input logic [3:0] exp_syn, input logic exp_err,
                       input logic exp_bad, input string tag);
    @(negedge clk);
    enc_data = d;
    dec_word = w;
    sb_exp.push_back({exp_enc, exp_dat, exp_syn, exp_err, exp_bad});
    sb_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    if (sb_exp.size() > 0) begin
      logic [25:0] e;
      logic [25:0] a;
      string t;
      e = sb_exp.pop_front();
      t = sb_tag.pop_front();
      a = {enc_word, dec_data, dec_syndrome, dec_error, dec_bad_pos};
      applied++;
      if (a !== e) begin
        miscompares++;
        $display("FAIL %s: enc=%h dat=%h syn=%h err=%b bad=%b expected enc=%h dat=%h syn=%h err=%b bad=%b",
                 t, a[25:14], a[13:6], a[5:2], a[1], a[0],
                 e[25:14], e[13:6], e[5:2], e[1], e[0]);
      end
    end
  end

  initial begin
    logic [11:0] cw;
    logic [11:0] bad;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R3: known vectors, the first one right after reset
    apply(8'h00, 12'h08B, 12'h08B, 8'h00, 4'd0, 1'b0, 1'b0, "R3 zero byte");
    apply(8'hB9, 12'hB4C, 12'hB4C, 8'hB9, 4'd0, 1'b0, 1'b0, "R3 known byte");
    // R1, R2, R4, R5: every byte, error-free
    for (int d = 0; d < 256; d++) begin
      cw = benc(8'(d));
      apply(8'(d), cw, cw, 8'(d), 4'd0, 1'b0, 1'b0, "R5 clean word");
    end
    // R6: every single-bit flip of every byte
    for (int d = 0; d < 256; d++) begin
      cw = benc(8'(d));
      for (int p = 1; p <= 12; p++) begin
        bad = cw ^ (12'd1 << (p - 1));
        apply(8'(d), bad, cw, 8'(d), 4'(p), 1'b1, 1'b0, "R6 single flip");
      end
    end
    // R7: paired flips whose syndrome is 13, 14 or 15
    for (int d = 0; d < 256; d += 17) begin
      cw = benc(8'(d));
      bad = cw ^ 12'h801;
      apply(8'(d), bad, cw, bext(bad), 4'd13, 1'b1, 1'b1, "R7 syndrome 13");
      bad = cw ^ 12'h802;
      apply(8'(d), bad, cw, bext(bad), 4'd14, 1'b1, 1'b1, "R7 syndrome 14");
      bad = cw ^ 12'h804;
      apply(8'(d), bad, cw, bext(bad), 4'd15, 1'b1, 1'b1, "R7 syndrome 15");
      bad = cw ^ 12'h108;
      apply(8'(d), bad, cw, bext(bad), 4'd13, 1'b1, 1'b1, "R7 syndrome 13 alt");
    end
    while (sb_exp.size() > 0) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule